// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

A single-port synchronous static memory with a registered input stage, a registered read path and an internal four-beat burst address generator. On every rising edge the block captures its select, load, step, write, order, address and write data into input registers. The access itself happens in the following cycle. A read word is placed in an output register, so it is driven one edge after the access. A single starting address can therefore feed four beats of data in a 3-1-1-1 pattern.

A load strobe latches a new starting address and a beat-order choice. Later selected cycles without a load continue the burst. In those cycles the step input either advances a two-bit beat counter or holds it. The counter wraps inside the aligned four-word block, and the beat order is either linear or interleaved. Writes store the captured data at the current beat address. A deselect turns the data drive off one edge after it is captured.

The depth is 2**ADDR_W words of DATA_W bits. ADDR_W = 15 gives the full 32K x 32 configuration. The default is a smaller 2K array so that elaboration stays light.

Top module: `psync_burst_ram`

## Requirements
- R1: The array holds 2**ADDR_W independent words of DATA_W bits (defaults 11 and 32). Address 0 and address 2**ADDR_W-1 are both usable.
- R2: A selected read cycle captured at rising edge N drives its word on rdata after edge N+1, with rdata_oe = 1.
- R3: In linear mode (order_xor = 0 captured with the load), beat k (counter k = 0..3) uses low address bits (start[1:0] + k) mod 4.
- R4: In interleaved mode (order_xor = 1 captured with the load), beat k uses low address bits start[1:0] XOR k. The order is latched at the load, and order_xor is ignored on continuation cycles.
- R5: On a selected continuation cycle with step = 0, the counter holds and the previous beat address is accessed again.
- R6: On a selected continuation cycle with step = 1, the counter advances by one and wraps from 3 to 0. Address bits above bit 1 never change within a burst.
- R7: A selected cycle with load = 1 starts a new burst at addr with counter 0, even in the middle of a burst. Step is ignored in that cycle.
- R8: A selected cycle with wr = 1 stores wdata at the current beat address and drives rdata_oe = 0 after the next edge. A later read of that address returns the new word.
- R9: A cycle captured with sel = 0 performs no access. It drives rdata_oe = 0 and rdata = 0 after the next edge, leaves the burst counter and start address unchanged, and ignores load.
- R10: A synchronous reset (rst = 1) clears rdata_oe and rdata, sets the burst start address and counter to 0, and selects linear order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| sel | input | 1 | Cycle select; 0 deselects the memory |
| load | input | 1 | Start a new burst at addr |
| step | input | 1 | Advance the beat counter on continuation cycles |
| wr | input | 1 | 1 = write cycle, 0 = read cycle |
| order_xor | input | 1 | Beat order latched at load: 1 interleaved, 0 linear |
| addr | input | ADDR_W | Burst starting word address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data, zero when not driven |
| rdata_oe | output | 1 | Read data drive enable |

## Verification
Every cycle, the assertions check how the burst counter and the start address move: cleared on load, held on a stall or a deselect, advanced and wrapped on a step. They also check when the data drive is on: one edge after a read, and off after a write or a deselect, with a zero word while off. Only the bench scenarios can show the beat sequences, meaning the linear and interleaved orders, the wrap at the top of the array and the order latching. The same holds for data integrity through the memory: write-then-read, restarts in mid-burst, and the start state after a reset.

// File: rtl/psram_pkg.sv
package psram_pkg;

  typedef enum logic {
    ORD_LINEAR = 1'b0,
    ORD_XOR    = 1'b1
  } beat_order_e;

  localparam int BEAT_BITS = 2;

  // Low word-address bits for a given beat of a burst.
  function automatic logic [BEAT_BITS-1:0] beat_low(
    input logic [BEAT_BITS-1:0] start_lo,
    input logic [BEAT_BITS-1:0] cnt,
    input beat_order_e          ord
  );
    logic [BEAT_BITS-1:0] r;
    if (ord == ORD_XOR) r = start_lo ^ cnt;
    else                r = start_lo + cnt;
    return r;
  endfunction

endpackage

// File: rtl/psram_in_regs.sv
module psram_in_regs #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              load,
  input  logic              step,
  input  logic              wr,
  input  logic              order_xor,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              q_sel,
  output logic              q_load,
  output logic              q_step,
  output logic              q_wr,
  output logic              q_ord,
  output logic [ADDR_W-1:0] q_addr,
  output logic [DATA_W-1:0] q_wdata
);

  // Control capture: cleared by reset so no access follows reset.
  always_ff @(posedge clk) begin
    if (rst) begin
      q_sel  <= 1'b0;
      q_load <= 1'b0;
      q_step <= 1'b0;
      q_wr   <= 1'b0;
      q_ord  <= 1'b0;
    end else begin
      q_sel  <= sel;
      q_load <= load;
      q_step <= step;
      q_wr   <= wr;
      q_ord  <= order_xor;
    end
  end

  // Datapath capture: no reset needed, qualified by q_sel.
  always_ff @(posedge clk) begin
    q_addr  <= addr;
    q_wdata <= wdata;
  end

endmodule

// File: rtl/psram_burst_gen.sv
module psram_burst_gen
  import psram_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc,
  input  logic              load,
  input  logic              step,
  input  logic              ord,
  input  logic [ADDR_W-1:0] start_addr,
  output logic [ADDR_W-1:0] beat_addr
);

  localparam int HI_W = ADDR_W - BEAT_BITS;

  logic [ADDR_W-1:0]    base_q;
  logic [BEAT_BITS-1:0] cnt_q;
  beat_order_e          ord_q;

  logic [ADDR_W-1:0]    base_c;
  logic [BEAT_BITS-1:0] cnt_c;
  beat_order_e          ord_c;

  always_comb begin
    if (load) begin
      base_c = start_addr;
      cnt_c  = '0;
      ord_c  = beat_order_e'(ord);
    end else begin
      base_c = base_q;
      cnt_c  = step ? cnt_q + 1'b1 : cnt_q;
      ord_c  = ord_q;
    end
  end

  assign beat_addr = {base_c[ADDR_W-1 -: HI_W],
                      beat_low(base_c[BEAT_BITS-1:0], cnt_c, ord_c)};

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      cnt_q  <= '0;
      ord_q  <= ORD_LINEAR;
    end else if (acc) begin
      base_q <= base_c;
      cnt_q  <= cnt_c;
      ord_q  <= ord_c;
    end
  end

  // R7: a load restarts the burst at the captured address
  assert_load_R7: assert property (@(posedge clk) disable iff (rst)
    acc && load |=> cnt_q == '0 && base_q == $past(start_addr));

  // R5: stall keeps the counter and start address
  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    acc && !load && !step |=> $stable(cnt_q) && $stable(base_q));

  // R6: a step advances modulo four inside the same block
  assert_step_R6: assert property (@(posedge clk) disable iff (rst)
    acc && !load && step |=> cnt_q == $past(cnt_q) + 2'd1 && $stable(base_q));

  // R9: a deselected cycle touches no burst state
  assert_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !acc |=> $stable(cnt_q) && $stable(base_q) && $stable(ord_q));

endmodule

// File: rtl/psram_array.sv
module psram_array #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en && we) mem[addr] <= wdata;
  end

  // Output register with synchronous reset, as block RAM provides.
  always_ff @(posedge clk) begin
    if (rst || !(en && !we)) rdata <= '0;
    else                     rdata <= mem[addr];
  end

  always_ff @(posedge clk) begin
    if (rst) rvalid <= 1'b0;
    else     rvalid <= en && !we;
  end

endmodule

// File: rtl/psync_burst_ram.sv
module psync_burst_ram #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              load,
  input  logic              step,
  input  logic              wr,
  input  logic              order_xor,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_oe
);

  logic              s_sel, s_load, s_step, s_wr, s_ord;
  logic [ADDR_W-1:0] s_addr;
  logic [DATA_W-1:0] s_wdata;
  logic [ADDR_W-1:0] beat_addr;

  psram_in_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_in (
    .clk(clk), .rst(rst), .sel(sel), .load(load), .step(step), .wr(wr),
    .order_xor(order_xor), .addr(addr), .wdata(wdata),
    .q_sel(s_sel), .q_load(s_load), .q_step(s_step), .q_wr(s_wr),
    .q_ord(s_ord), .q_addr(s_addr), .q_wdata(s_wdata)
  );

  psram_burst_gen #(.ADDR_W(ADDR_W)) u_burst (
    .clk(clk), .rst(rst), .acc(s_sel), .load(s_load), .step(s_step),
    .ord(s_ord), .start_addr(s_addr), .beat_addr(beat_addr)
  );

  psram_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk(clk), .rst(rst), .en(s_sel), .we(s_wr), .addr(beat_addr),
    .wdata(s_wdata), .rdata(rdata), .rvalid(rdata_oe)
  );

  // R2: a captured read drives data one edge later
  assert_rd_lat_R2: assert property (@(posedge clk) disable iff (rst)
    s_sel && !s_wr |=> rdata_oe);

  // R8: write cycles leave the data drive off
  assert_wr_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    s_sel && s_wr |=> !rdata_oe);

  // R9: deselect turns the drive off one edge after capture
  assert_desel_R9: assert property (@(posedge clk) disable iff (rst)
    !s_sel |=> !rdata_oe);

  // R9: an undriven bus carries a zero word
  assert_zero_off_R9: assert property (@(posedge clk) disable iff (rst)
    !rdata_oe |-> rdata == '0);

endmodule

// File: tb/tb_psync_burst_ram.sv
module tb_psync_burst_ram;

  localparam int AW = 11;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          sel = 1'b0, load = 1'b0, step = 1'b0, wr = 1'b0, order_xor = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          rdata_oe;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;  // 50 MHz

  psync_burst_ram #(.ADDR_W(AW), .DATA_W(DW)) dut (
    .clk(clk), .rst(rst), .sel(sel), .load(load), .step(step), .wr(wr),
    .order_xor(order_xor), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rdata_oe(rdata_oe)
  );

  function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
    return 32'hC0DE_0000 | {21'b0, a};
  endfunction

  typedef struct packed {
    logic          live;
    logic          ev;
    logic [DW-1:0] ed;
    logic [3:0]    req;
  } slot_t;

  slot_t q0 = '0, q1 = '0;

  task automatic compare(input slot_t s);
    if (s.live) begin
      n_cmp++;
      if (rdata_oe !== s.ev || rdata !== (s.ev ? s.ed : '0)) begin
        n_bad++;
        $display("FAIL R%0d: oe=%0b data=%h expected oe=%0b data=%h",
                 s.req, rdata_oe, rdata, s.ev, s.ev ? s.ed : '0);
      end
    end
  endtask

  // Drive one cycle; the result shows two falling edges later.
  task automatic drive(input bit c, input bit i_sel, input bit i_load,
                       input bit i_step, input bit i_wr, input bit i_ord,
                       input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input bit ev, input logic [DW-1:0] ed, input int req);
    slot_t n;
    @(negedge clk);
    compare(q1);
    n.live = c; n.ev = ev; n.ed = ed; n.req = 4'(req);
    q1 = q0; q0 = n;
    sel = i_sel; load = i_load; step = i_step; wr = i_wr; order_xor = i_ord;
    addr = a; wdata = d;
  endtask

  typedef struct packed {
    logic          sel, load, step, ord;
    logic [AW-1:0] a;
    logic          ev;
    logic [AW-1:0] ea;
    logic [3:0]    req;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t VEC [NV] = '{
    '{1'b1,1'b1,1'b0,1'b0,11'd6,   1'b1,11'd6,   4'd2},  // R2 first beat
    '{1'b1,1'b0,1'b1,1'b0,11'd0,   1'b1,11'd7,   4'd3},  // R3 linear
    '{1'b1,1'b0,1'b1,1'b0,11'd0,   1'b1,11'd4,   4'd3},  // R3
    '{1'b1,1'b0,1'b1,1'b0,11'd0,   1'b1,11'd5,   4'd3},  // R3
    '{1'b1,1'b0,1'b1,1'b0,11'd0,   1'b1,11'd6,   4'd6},  // R6 wrap
    '{1'b1,1'b1,1'b0,1'b1,11'd9,   1'b1,11'd9,   4'd4},  // R4 interleaved
    '{1'b1,1'b0,1'b1,1'b1,11'd0,   1'b1,11'd8,   4'd4},  // R4
    '{1'b1,1'b0,1'b1,1'b1,11'd0,   1'b1,11'd11,  4'd4},  // R4
    '{1'b1,1'b0,1'b1,1'b1,11'd0,   1'b1,11'd10,  4'd4},  // R4
    '{1'b1,1'b0,1'b1,1'b1,11'd0,   1'b1,11'd9,   4'd6},  // R6 wrap
    '{1'b1,1'b1,1'b0,1'b0,11'd13,  1'b1,11'd13,  4'd5},  // R5 hold
    '{1'b1,1'b0,1'b0,1'b0,11'd0,   1'b1,11'd13,  4'd5},  // R5
    '{1'b1,1'b0,1'b1,1'b0,11'd0,   1'b1,11'd14,  4'd5},  // R5
    '{1'b1,1'b0,1'b0,1'b0,11'd0,   1'b1,11'd14,  4'd5},  // R5
    '{1'b1,1'b1,1'b0,1'b0,11'd2,   1'b1,11'd2,   4'd7},  // R7 restart
    '{1'b1,1'b0,1'b1,1'b0,11'd0,   1'b1,11'd3,   4'd7},  // R7
    '{1'b1,1'b1,1'b1,1'b1,11'd5,   1'b1,11'd5,   4'd7},  // R7 step ignored
    '{1'b1,1'b0,1'b1,1'b1,11'd0,   1'b1,11'd4,   4'd7},  // R7
    '{1'b0,1'b0,1'b1,1'b0,11'd0,   1'b0,11'd0,   4'd9},  // R9 deselect
    '{1'b0,1'b1,1'b0,1'b0,11'd12,  1'b0,11'd0,   4'd9},  // R9 load ignored
    '{1'b1,1'b0,1'b1,1'b1,11'd0,   1'b1,11'd7,   4'd9},  // R9 counter kept
    '{1'b1,1'b1,1'b0,1'b0,11'd2046,1'b1,11'd2046,4'd1},  // R1 top
    '{1'b1,1'b0,1'b1,1'b0,11'd0,   1'b1,11'd2047,4'd1},  // R1
    '{1'b1,1'b0,1'b1,1'b0,11'd0,   1'b1,11'd2044,4'd6},  // R6 upper bits
    '{1'b1,1'b0,1'b1,1'b0,11'd0,   1'b1,11'd2045,4'd6},  // R6
    '{1'b1,1'b1,1'b0,1'b0,11'd1,   1'b1,11'd1,   4'd4},  // R4 latched order
    '{1'b1,1'b0,1'b1,1'b1,11'd0,   1'b1,11'd2,   4'd4},  // R4
    '{1'b1,1'b1,1'b0,1'b0,11'd0,   1'b1,11'd0,   4'd1}   // R1 lowest
  };

  task automatic idle(input bit c, input int req);
    drive(c, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0, '0, 1'b0, '0, req);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run hung, expected completion");
    finish_run();
  end

  initial begin
    // R10: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_cmp++;
    if (rdata_oe !== 1'b0 || rdata !== '0) begin
      n_bad++;
      $display("FAIL R10: oe=%0b data=%h expected oe=0 data=0", rdata_oe, rdata);
    end
    rst = 1'b0;

    // Preload: single-beat writes, unchecked
    for (int a = 0; a < 16; a++)
      drive(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, AW'(a), pat(AW'(a)), 1'b0, '0, 8);
    for (int a = 2044; a < 2048; a++)
      drive(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, AW'(a), pat(AW'(a)), 1'b0, '0, 8);

    // Vector walk
    for (int i = 0; i < NV; i++)
      drive(1'b1, VEC[i].sel, VEC[i].load, VEC[i].step, 1'b0, VEC[i].ord,
            VEC[i].a, '0, VEC[i].ev, pat(VEC[i].ea), int'(VEC[i].req));

    // R8: burst write at 20..22, then read back immediately
    drive(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 11'd20, 32'h1111_AAAA, 1'b0, '0, 8);
    drive(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 11'd0,  32'h2222_BBBB, 1'b0, '0, 8);
    drive(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 11'd0,  32'h3333_CCCC, 1'b0, '0, 8);
    drive(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 11'd21, '0, 1'b1, 32'h2222_BBBB, 8);
    drive(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 11'd0,  '0, 1'b1, 32'h3333_CCCC, 8);
    drive(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 11'd20, '0, 1'b1, 32'h1111_AAAA, 8);
    // R8: overwrite a preloaded word with a new one
    drive(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 11'd3,  32'h4444_DDDD, 1'b0, '0, 8);
    drive(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 11'd3,  '0, 1'b1, 32'h4444_DDDD, 8);
    idle(1'b1, 9);
    idle(1'b1, 9);

    // R10: reset in mid-burst (interleaved from 9), then continue without load
    drive(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 11'd9, '0, 1'b0, '0, 10);
    drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 11'd0, '0, 1'b0, '0, 10);
    @(negedge clk);
    rst = 1'b1; sel = 1'b0; load = 1'b0; step = 1'b0;
    q0 = '0; q1 = '0;
    @(negedge clk);
    n_cmp++;
    if (rdata_oe !== 1'b0 || rdata !== '0) begin
      n_bad++;
      $display("FAIL R10: oe=%0b data=%h expected oe=0 data=0", rdata_oe, rdata);
    end
    rst = 1'b0;
    // Counter cleared to 0, base 0, linear: a step reaches address 1
    drive(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 11'd0, '0, 1'b1, pat(11'd1), 10);
    drive(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 11'd0, '0, 1'b1, pat(11'd2), 10);
    idle(1'b1, 9);
    idle(1'b1, 9);
    idle(1'b0, 9);

    finish_run();
  end

endmodule